// File: doc/BRIEF.md
# Unified Modular Divide / Montgomery Multiply Engine

This block is an iterative arithmetic unit for public-key and curve arithmetic. One control loop produces either a Montgomery product X·Y·2^-N mod p or a modular quotient X/Y mod p. The operands live in a prime field (integers modulo an odd p below 2^N) or in a binary polynomial field (polynomials modulo an irreducible p(x) of degree N). Two mode inputs pick the operation and the field. A single strobe latches the operands, and a one-clock `done` pulse marks a valid result on `z_out`.

Four working words (C, D, U, W) and a signed counter `delta` step through a binary-GCD recurrence for division and a bit-serial Montgomery recurrence for multiplication. The counter tracks the size difference between C and D, so no magnitude comparison is needed. An exchange of the C/D and U/W pairs flips one mapping flag, and no data moves. In the prime field the words are signed and wider than N. A short correction phase fixes the sign of the quotient and brings the result into [0, p).

Operation and field encodings: `op_div` = 0 selects Montgomery multiplication and 1 selects division. `fld_bin` = 0 selects the prime field and 1 selects the binary field, where addition and subtraction are bitwise XOR.

Top module: `umdm_engine`

## Requirements
- R1: While `rst` is high, and after it falls until the first result, `done` is 0 and `z_out` is 0.
- R2: With `op_div`=0 and `fld_bin`=0, the result equals X·Y·2^-N mod p and lies in [0, p).
- R3: With `op_div`=0 and `fld_bin`=1, the result equals X(x)·Y(x)·x^-N mod p(x), with degree below N.
- R4: A multiplication raises `done` N+3 clock edges after the edge that samples `start`. In the prime field it may take N+4 edges, when one final subtraction of p is needed.
- R5: With `op_div`=1 and `fld_bin`=0, the result Z satisfies Z·Y ≡ X (mod p) and lies in [0, p).
- R6: With `op_div`=1 and `fld_bin`=1, the result Z(x) satisfies Z(x)·Y(x) ≡ X(x) (mod p(x)).
- R7: With X=1, division returns the multiplicative inverse of Y in either field.
- R8: `done` is high for exactly one clock per operation. `z_out` changes only on that clock and then holds until the next result.
- R9: A `start` that arrives while an operation is in progress is ignored. The running operation finishes on its original operands, and no extra result is produced.
- R10: In a prime-field odd division step, C is combined with D by addition when the two low bits of C plus the two low bits of D give 0 mod 4, and by subtraction otherwise. In the binary field the combination is always XOR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operand latch strobe, honoured only when idle |
| op_div | input | 1 | 0 = Montgomery multiply, 1 = divide |
| fld_bin | input | 1 | 0 = prime field, 1 = binary polynomial field |
| x_in | input | N | Dividend or multiplicand |
| y_in | input | N | Divisor or multiplier; nonzero for division |
| p_in | input | N+1 | Modulus: odd prime below 2^N, or irreducible polynomial of degree N |
| z_out | output | N | Registered result |
| done | output | 1 | One-clock pulse when `z_out` is updated |

## Verification
The assertions assume legal operands. The modulus must be odd (a prime below 2^N, or an irreducible polynomial with bit N set). X must already be reduced below p, and Y must be nonzero and coprime to p when dividing. Only under these conditions are the result-range and latency properties valid. The range check compares against the modulus captured at start, so changing `p_in` during a run does not break it. The stimulus uses only the prime moduli 251 and 13 and the polynomial x^8+x^4+x^3+x+1. Every operand is reduced modulo p, and divisors are forced nonzero, so every case stays inside these assumptions.

// File: rtl/umdm_pkg.sv
package umdm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_MUL, ST_STEP, ST_EVEN2, ST_ODD2, ST_ODD3, ST_FIN, ST_FIX
  } umdm_state_e;

  localparam logic [1:0] ROLE_W = 2'd0;
  localparam logic [1:0] ROLE_U = 2'd1;
  localparam logic [1:0] ROLE_D = 2'd2;
  localparam logic [1:0] ROLE_C = 2'd3;
endpackage

// File: rtl/umdm_addsub.sv
module umdm_addsub #(
  parameter int WW = 12
) (
  input  logic signed [WW-1:0] a,
  input  logic signed [WW-1:0] b,
  input  logic                 sub,
  input  logic                 binf,
  output logic signed [WW-1:0] y
);
  always_comb begin
    if (binf)     y = a ^ b;
    else if (sub) y = a - b;
    else          y = a + b;
  end
endmodule

// File: rtl/umdm_halver.sv
module umdm_halver #(
  parameter int WW = 12
) (
  input  logic signed [WW-1:0] u,
  input  logic signed [WW-1:0] p,
  input  logic                 binf,
  output logic signed [WW-1:0] y
);
  logic signed [WW-1:0] even_v;

  always_comb begin
    if (!u[0])     even_v = u;
    else if (binf) even_v = u ^ p;
    else           even_v = u + p;
    y = even_v >>> 1;
  end
endmodule

// File: rtl/umdm_regbank.sv
module umdm_regbank #(
  parameter int WW   = 12,
  parameter int NREG = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               load,
  input  logic [NREG*WW-1:0] init_flat,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [WW-1:0]      wdata,
  output logic [NREG*WW-1:0] q_flat
);
  logic [WW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < NREG; i++) mem[i] <= init_flat[i*WW +: WW];
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign q_flat[g*WW +: WW] = mem[g];
  end
endmodule

// File: rtl/umdm_engine.sv
module umdm_engine #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         op_div,
  input  logic         fld_bin,
  input  logic [N-1:0] x_in,
  input  logic [N-1:0] y_in,
  input  logic [N:0]   p_in,
  output logic [N-1:0] z_out,
  output logic         done
);
  import umdm_pkg::*;

  localparam int WW = N + $clog2(N) + 3;
  localparam int DW = $clog2(N) + 3;
  typedef logic signed [WW-1:0] word_t;

  umdm_state_e          state_q;
  logic                 swp_q, kneg_q, op_q, bin_q;
  logic signed [DW-1:0] delta_q;
  logic [N-1:0]         ysh_q;
  logic [N:0]           p_q;
  word_t                acc_q;
  logic [N-1:0]         z_q;
  logic                 done_q;
  logic                 busy_w;

  logic [4*WW-1:0] rf_q, rf_init;
  logic            rf_load, rf_we;
  logic [1:0]      rf_waddr;
  word_t           rf_wdata;
  word_t           rf_w [4];

  word_t w_v, u_v, d_v, c_v, p_ext;
  word_t ue, wes, ce, de;
  word_t add_a, add_b, sum_y, half_y, shr_y;
  logic  add_sub, swap_now, swp_n, kneg_now;
  logic [1:0] low_sum;

  function automatic logic [1:0] slot(input logic [1:0] role, input logic swp);
    return role ^ {1'b0, swp};
  endfunction

  for (genvar g = 0; g < 4; g++) begin : g_split
    assign rf_w[g] = rf_q[g*WW +: WW];
  end

  assign p_ext = word_t'({{(WW-N-1){1'b0}}, p_q});
  assign w_v   = rf_w[slot(ROLE_W, swp_q)];
  assign u_v   = rf_w[slot(ROLE_U, swp_q)];
  assign d_v   = rf_w[slot(ROLE_D, swp_q)];
  assign c_v   = rf_w[slot(ROLE_C, swp_q)];

  // odd-step view after a possible exchange
  assign swap_now = delta_q[DW-1];
  assign swp_n    = swp_q ^ swap_now;
  assign ue       = swap_now ? w_v : u_v;
  assign wes      = swap_now ? u_v : w_v;
  assign ce       = swap_now ? d_v : c_v;
  assign de       = swap_now ? c_v : d_v;
  assign low_sum  = ce[1:0] + de[1:0];
  assign kneg_now = !bin_q && (low_sum != 2'b00);

  assign busy_w  = (state_q != ST_IDLE);
  assign rf_load = (state_q == ST_IDLE) && start;
  assign shr_y   = sum_y >>> 1;

  always_comb begin
    rf_init = '0;
    rf_init[ROLE_W*WW +: WW] = op_div ? '0 : WW'(x_in);
    rf_init[ROLE_U*WW +: WW] = op_div ? WW'(x_in) : '0;
    rf_init[ROLE_D*WW +: WW] = op_div ? WW'(p_in) : '0;
    rf_init[ROLE_C*WW +: WW] = WW'(y_in);
  end

  umdm_addsub #(.WW(WW)) u_add (
    .a(add_a), .b(add_b), .sub(add_sub), .binf(bin_q), .y(sum_y)
  );

  umdm_halver #(.WW(WW)) u_half (
    .u(sum_y), .p(p_ext), .binf(bin_q), .y(half_y)
  );

  umdm_regbank #(.WW(WW), .NREG(4)) u_rf (
    .clk(clk), .load(rf_load), .init_flat(rf_init), .we(rf_we),
    .waddr(rf_waddr), .wdata(rf_wdata), .q_flat(rf_q)
  );

  always_comb begin
    add_a    = u_v;
    add_b    = '0;
    add_sub  = 1'b0;
    rf_we    = 1'b0;
    rf_waddr = slot(ROLE_U, swp_q);
    rf_wdata = half_y;
    unique case (state_q)
      ST_MUL: begin
        if (delta_q != '0) begin
          add_b = ysh_q[0] ? w_v : '0;
          rf_we = 1'b1;
        end
      end
      ST_STEP: begin
        if (c_v != '0) begin
          rf_we = 1'b1;
          if (c_v[0]) begin
            add_a    = ue;
            add_b    = wes;
            add_sub  = kneg_now;
            rf_waddr = slot(ROLE_U, swp_n);
            rf_wdata = sum_y;
          end
        end
      end
      ST_ODD2: rf_we = 1'b1;
      ST_EVEN2, ST_ODD3: begin
        add_a    = c_v;
        add_b    = (state_q == ST_ODD3) ? d_v : '0;
        add_sub  = (state_q == ST_ODD3) && kneg_q;
        rf_we    = 1'b1;
        rf_waddr = slot(ROLE_C, swp_q);
        rf_wdata = shr_y;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      swp_q   <= 1'b0;
      kneg_q  <= 1'b0;
      op_q    <= 1'b0;
      bin_q   <= 1'b0;
      delta_q <= '0;
      ysh_q   <= '0;
      p_q     <= '0;
      acc_q   <= '0;
      z_q     <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            op_q    <= op_div;
            bin_q   <= fld_bin;
            p_q     <= p_in;
            swp_q   <= 1'b0;
            ysh_q   <= y_in;
            delta_q <= op_div ? '0 : DW'(N);
            state_q <= op_div ? ST_STEP : ST_MUL;
          end
        end
        ST_MUL: begin
          if (delta_q == '0) begin
            state_q <= ST_FIN;
          end else begin
            delta_q <= delta_q - 1'b1;
            ysh_q   <= ysh_q >> 1;
          end
        end
        ST_STEP: begin
          if (c_v == '0) begin
            state_q <= ST_FIN;
          end else if (!c_v[0]) begin
            state_q <= ST_EVEN2;
          end else begin
            swp_q   <= swp_n;
            kneg_q  <= kneg_now;
            delta_q <= swap_now ? -delta_q : delta_q;
            state_q <= ST_ODD2;
          end
        end
        ST_EVEN2: begin
          delta_q <= delta_q - 1'b1;
          state_q <= ST_STEP;
        end
        ST_ODD2: state_q <= ST_ODD3;
        ST_ODD3: begin
          delta_q <= delta_q - 1'b1;
          state_q <= ST_STEP;
        end
        ST_FIN: begin
          if (!op_q)                   acc_q <= u_v;
          else if (!bin_q && d_v < 0)  acc_q <= -w_v;
          else                         acc_q <= w_v;
          state_q <= ST_FIX;
        end
        ST_FIX: begin
          if (bin_q || (acc_q >= 0 && acc_q < p_ext)) begin
            z_q     <= acc_q[N-1:0];
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (acc_q < 0) begin
            acc_q <= acc_q + p_ext;
          end else begin
            acc_q <= acc_q - p_ext;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign z_out = z_q;
  assign done  = done_q;
endmodule

// File: rtl/umdm_engine_chk.sv
module umdm_engine_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [N-1:0] z,
  input logic [N:0]   pmod,
  input logic         op_div,
  input logic         fld_bin
);
  logic [15:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (start && !busy) cnt <= '0;
    else if (cnt != '1)      cnt <= cnt + 1'b1;
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  z_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(z));

  // R2 R5
  z_range_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !fld_bin) |-> ({1'b0, z} < pmod));

  // R4
  bin_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !op_div && fld_bin) |-> (cnt == 16'(N + 3)));

  // R4
  prime_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !op_div && !fld_bin) |-> (cnt == 16'(N + 3) || cnt == 16'(N + 4)));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));
endmodule

bind umdm_engine umdm_engine_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy_w), .done(done),
  .z(z_out), .pmod(p_q), .op_div(op_q), .fld_bin(bin_q)
);

// File: tb/umdm_engine_bench.sv
`timescale 1ns/1ps
module umdm_engine_bench;
  localparam int N = 8;
  localparam int PB = 32'h11B;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         op_div = 1'b0;
  logic         fld_bin = 1'b0;
  logic [N-1:0] x_in = '0;
  logic [N-1:0] y_in = '0;
  logic [N:0]   p_in = '0;
  logic [N-1:0] z_out;
  logic         done;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;
  int  lcg = 12345;

  always #2 clk = ~clk;

  umdm_engine #(.N(N)) u_umdm_engine (
    .clk(clk), .rst(rst), .start(start), .op_div(op_div), .fld_bin(fld_bin),
    .x_in(x_in), .y_in(y_in), .p_in(p_in), .z_out(z_out), .done(done)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int next_rand();
    lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
    return lcg;
  endfunction

  function automatic int gf_mul(input int a, input int b, input int p);
    int r = 0;
    for (int i = N - 1; i >= 0; i--) begin
      r = r << 1;
      if ((r >> N) & 1) r = r ^ p;
      if ((b >> i) & 1) r = r ^ a;
    end
    return r;
  endfunction

  function automatic int ref_mont_p(input int x, input int y, input int p);
    for (int z = 0; z < p; z++)
      if ((longint'(z) * (1 << N)) % p == (longint'(x) * y) % p) return z;
    return -1;
  endfunction

  function automatic int ref_mont_b(input int x, input int y, input int p);
    int xn = p & ((1 << N) - 1);
    for (int z = 0; z < (1 << N); z++)
      if (gf_mul(z, xn, p) == gf_mul(x, y, p)) return z;
    return -1;
  endfunction

  function automatic int ref_div_p(input int x, input int y, input int p);
    for (int z = 0; z < p; z++)
      if ((longint'(z) * y) % p == x % p) return z;
    return -1;
  endfunction

  function automatic int ref_div_b(input int x, input int y, input int p);
    for (int z = 0; z < (1 << N); z++)
      if (gf_mul(z, y, p) == x) return z;
    return -1;
  endfunction

  task automatic run(input bit dv, input bit bf, input int x, input int y, input int p,
                     output int z, output int cyc);
    @(negedge clk);
    op_div = dv; fld_bin = bf;
    x_in = x[N-1:0]; y_in = y[N-1:0]; p_in = p[N:0];
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    cyc = 0;
    do begin
      @(posedge clk); #1;
      cyc++;
    end while (!done && cyc < 5000);
    check(cyc < 5000, "R8 done timeout", cyc, 0);
    z = int'(z_out);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(z_out == '0, "R1 z in reset", z_out, 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check(done == 1'b0 && z_out == '0, "R1 after reset", z_out, 0);
  endtask

  task automatic t_mul_prime();
    int z, c, x, y, e;
    for (int i = 0; i < 6; i++) begin
      x = (i == 0) ? 250 : (i == 1) ? 0 : next_rand() % 251;
      y = (i == 0) ? 250 : (i == 1) ? 77 : next_rand() % 251;
      run(1'b0, 1'b0, x, y, 251, z, c);
      e = ref_mont_p(x, y, 251);
      check(z == e, "R2 prime montgomery", z, e);
      check(c == N + 3 || c == N + 4, "R4 prime mult latency", c, N + 3);
    end
    run(1'b0, 1'b0, 12, 11, 13, z, c);
    e = ref_mont_p(12, 11, 13);
    check(z == e, "R2 prime montgomery small p", z, e);
  endtask

  task automatic t_mul_bin();
    int z, c, x, y, e;
    for (int i = 0; i < 6; i++) begin
      x = (i == 0) ? 255 : next_rand() % 256;
      y = (i == 0) ? 255 : next_rand() % 256;
      run(1'b0, 1'b1, x, y, PB, z, c);
      e = ref_mont_b(x, y, PB);
      check(z == e, "R3 binary montgomery", z, e);
      check(c == N + 3, "R4 binary mult latency", c, N + 3);
    end
  endtask

  task automatic t_div_prime();
    int z, c, x, y, e;
    for (int i = 0; i < 6; i++) begin
      x = (i == 0) ? 250 : next_rand() % 251;
      y = (i == 0) ? 250 : 1 + next_rand() % 250;
      run(1'b1, 1'b0, x, y, 251, z, c);
      e = ref_div_p(x, y, 251);
      // R10 sign choice is exercised through these quotients
      check(z == e, "R5 R10 prime division", z, e);
    end
    run(1'b1, 1'b0, 9, 1, 13, z, c);
    check(z == 9, "R5 prime division by one", z, 9);
    run(1'b1, 1'b0, 0, 5, 13, z, c);
    check(z == 0, "R5 prime zero dividend", z, 0);
  endtask

  task automatic t_div_bin();
    int z, c, x, y, e;
    for (int i = 0; i < 6; i++) begin
      x = next_rand() % 256;
      y = 1 + next_rand() % 255;
      run(1'b1, 1'b1, x, y, PB, z, c);
      e = ref_div_b(x, y, PB);
      check(z == e, "R6 R10 binary division", z, e);
    end
  endtask

  task automatic t_inverse();
    int z, c, e;
    run(1'b1, 1'b0, 1, 3, 251, z, c);
    e = ref_div_p(1, 3, 251);
    check(z == e, "R7 prime inverse", z, e);
    run(1'b1, 1'b0, 1, 250, 251, z, c);
    check(z == 250, "R7 prime inverse of minus one", z, 250);
    run(1'b1, 1'b1, 1, 8'h53, PB, z, c);
    check(z == 8'hCA, "R7 binary inverse", z, 8'hCA);
  endtask

  task automatic t_pulse();
    int z, c;
    logic [N-1:0] held;
    run(1'b0, 1'b1, 8'h57, 8'h83, PB, z, c);
    held = z_out;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      check(done == 1'b0, "R8 done single cycle", done, 0);
      check(z_out == held, "R8 z holds", z_out, held);
    end
  endtask

  task automatic t_busy();
    int cyc, e;
    e = ref_mont_p(100, 200, 251);
    @(negedge clk);
    op_div = 1'b0; fld_bin = 1'b0; x_in = 8'd100; y_in = 8'd200; p_in = 9'd251;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    cyc = 0;
    repeat (3) begin
      @(posedge clk); #1; cyc++;
    end
    @(negedge clk);
    op_div = 1'b1; fld_bin = 1'b1; x_in = 8'd7; y_in = 8'd9; p_in = 9'(PB);
    start = 1'b1;
    @(posedge clk); #1; cyc++;
    start = 1'b0;
    while (!done && cyc < 5000) begin
      @(posedge clk); #1; cyc++;
    end
    check(int'(z_out) == e, "R9 start ignored while busy", z_out, e);
    check(cyc == N + 3 || cyc == N + 4, "R9 original timing kept", cyc, N + 3);
    for (int i = 0; i < 2 * N; i++) begin
      @(posedge clk); #1;
      check(done == 1'b0, "R9 no extra result", done, 0);
    end
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_mul_prime();
    t_mul_bin();
    t_div_prime();
    t_div_bin();
    t_inverse();
    t_pulse();
    t_busy();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule